// File: doc/BRIEF.md
# Scanline Window Wait Unit

This unit holds a display command engine until the current scanline is inside a chosen window, or outside it. The engine passes in one decoded wait instruction as two 32-bit words. The unit captures the opcode and the two packed bounds, then compares them against the scanline counter on every clock. It reports completion with a one-cycle `done` pulse.

Bounds are already in hardware scanline numbering, from 0 to vtotal−1. A window is an inclusive range with the lower bound no greater than the upper bound. A window that wraps past the end of the frame is written as its complement with the opposite wait sense.

The typical uses are evading the register-arming region before vertical blank, and staying away from scanline 0. The counter reads 0 while the display sleeps.

Top module: `scanWindowWait`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: An instruction whose opcode (`instHi[31:24]`) is 0x05 is accepted when idle. The wait then finishes when the registered scanline is within [lower, upper].
- R3: Opcode 0x06 waits until the registered scanline is below lower or above upper.
- R4: The 64-bit window is `{instHi, instLo}`. Lower is window bits 19:0 (`instLo[19:0]`). Upper is window bits 39:20 (`{instHi[7:0], instLo[31:20]}`). `instHi[23:8]` is ignored.
- R5: Both bounds are inclusive. A scanline equal to lower or to upper counts as inside, including a one-line window.
- R6: `done` is high for exactly one cycle. `busy` is low in that same cycle, and a new instruction may be accepted then.
- R7: The scanline input is registered. If it already satisfies the condition when the instruction is accepted at edge A, `busy` is high between edge A and edge A+1, and `done` is high in the cycle after edge A+1.
- R8: `abort` while busy returns the unit to idle at the next edge without `done`, even when the condition is met in that same cycle. `abort` while idle has no effect.
- R9: `instValid` is ignored in two cases: when the opcode is neither 0x05 nor 0x06, and while a wait is pending. A pending wait keeps its original bounds.
- R10: An outside-wait on the window [0,0] stays busy while the scanline reads 0, and finishes once it reads any nonzero line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction words are valid this cycle |
| instLo | input | 32 | Lower instruction word (window bits 31:0) |
| instHi | input | 32 | Upper instruction word (opcode in 31:24, window bits 39:32 in 7:0) |
| scanLine | input | 20 | Current hardware scanline |
| abort | input | 1 | Cancel a pending wait |
| busy | output | 1 | A wait is pending |
| done | output | 1 | One-cycle completion pulse |

## Verification
The scanline is walked toward the window from below and from above, one line per cycle. This shows that the compare is inclusive at each bound and not off by one on either side. Inside and outside waits run on the same windows, including a one-line window and [0,0], so that an inverted sense is caught. A condition that is true on arrival checks the two-clock latency. Aborts are placed both early and on the very cycle the condition is met. Foreign opcodes, and instructions sent while busy, carry bounds that would complete at once if accepted. Upper bounds with bits above 11 set, plus junk in the reserved bits, separate correct field extraction from a wrong slice.

// File: rtl/sww_pkg.sv
package sww_pkg;
  localparam logic [7:0] OPC_INSIDE  = 8'h05;
  localparam logic [7:0] OPC_OUTSIDE = 8'h06;

  typedef struct packed {
    logic load;   // capture bounds and sense this edge
    logic armed;  // a wait is pending
  } swwStrobe_t;
endpackage

// File: rtl/swwDatapath.sv
module swwDatapath
  import sww_pkg::*;
#(
  parameter int LINE_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  swwStrobe_t        strobe,
  input  logic [31:0]       instLo,
  input  logic [31:0]       instHi,
  input  logic [LINE_W-1:0] scanLine,
  output logic              met
);
  localparam int WIN_W = 64;
  localparam int LO_LSB = 0;
  localparam int HI_LSB = LINE_W;

  logic [WIN_W-1:0]  window;
  logic [LINE_W-1:0] scanQ, loQ, hiQ;
  logic              outsideQ;
  logic              inWin;

  assign window = {instHi, instLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanQ    <= '0;
      loQ      <= '0;
      hiQ      <= '0;
      outsideQ <= 1'b0;
    end else begin
      scanQ <= scanLine;
      if (strobe.load) begin
        loQ      <= window[LO_LSB +: LINE_W];
        hiQ      <= window[HI_LSB +: LINE_W];
        outsideQ <= (instHi[31:24] == OPC_OUTSIDE);
      end
    end
  end

  assign inWin = (scanQ >= loQ) && (scanQ <= hiQ);
  assign met   = strobe.armed && (inWin != outsideQ);

  // R9: bounds of a pending wait never change
  a_r9_bounds_held: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armed && $past(strobe.armed)) |-> ($stable(loQ) && $stable(hiQ) && $stable(outsideQ)));
  // R9: nothing is loaded while a wait is pending
  a_r9_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobe.armed |-> !strobe.load);
endmodule

// File: rtl/swwCtrl.sv
module swwCtrl
  import sww_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [7:0] opcode,
  input  logic       abort,
  input  logic       met,
  output swwStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;
  state_t state;
  logic   doneQ;
  logic   isWaitOp, accept;

  assign isWaitOp = (opcode == OPC_INSIDE) || (opcode == OPC_OUTSIDE);
  assign accept   = (state == ST_IDLE) && instValid && isWaitOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      doneQ <= (state == ST_WAIT) && met && !abort;
      case (state)
        ST_IDLE: if (accept) state <= ST_WAIT;
        ST_WAIT: if (abort || met) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.load  = accept;
  assign strobe.armed = (state == ST_WAIT);
  assign busy = (state == ST_WAIT);
  assign done = doneQ;

  // R6: done lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: unit is idle when done is shown
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R2: done only follows a pending wait
  a_r2_done_after_wait: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));
  // R8: abort ends the wait silently
  a_r8_abort_silent: assert property (@(posedge clk) disable iff (!rstN)
    (busy && abort) |=> (!done && !busy));
  // R9: foreign opcodes never start a wait
  a_r9_foreign_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && instValid && !isWaitOp) |=> !busy);
endmodule

// File: rtl/scanWindowWait.sv
module scanWindowWait
  import sww_pkg::*;
#(
  parameter int LINE_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instLo,
  input  logic [31:0]       instHi,
  input  logic [LINE_W-1:0] scanLine,
  input  logic              abort,
  output logic              busy,
  output logic              done
);
  swwStrobe_t strobe;
  logic       met;

  swwCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opcode(instHi[31:24]),
    .abort(abort), .met(met), .strobe(strobe), .busy(busy), .done(done)
  );

  swwDatapath #(.LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instLo(instLo), .instHi(instHi),
    .scanLine(scanLine), .met(met)
  );
endmodule

// File: tb/scanWindowWait_tb.sv
module scanWindowWait_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instLo = '0, instHi = '0;
  logic [19:0] scanLine = '0;
  logic        abort = 1'b0;
  logic        busy, done;

  int tbOp = 0, tbLo = 0, tbHi = 0;
  int mLo = 0, mHi = 0, mScan = 0;
  bit mBusy = 0, mDone = 0, mOut = 0;
  int nChecks = 0, nFail = 0, cyc = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  scanWindowWait u_dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instLo(instLo), .instHi(instHi),
    .scanLine(scanLine), .abort(abort), .busy(busy), .done(done)
  );

  // behavioural reference
  always @(posedge clk) begin
    bit metNow, nd;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mScan = 0;
    end else begin
      metNow = mBusy && (((mScan >= mLo) && (mScan <= mHi)) != mOut);
      nd = mBusy && !abort && metNow;
      if (mBusy && (abort || metNow)) mBusy = 0;
      else if (!mBusy && instValid && (tbOp == 5 || tbOp == 6)) begin
        mBusy = 1; mLo = tbLo; mHi = tbHi; mOut = (tbOp == 6);
      end
      mScan = int'(scanLine);
      mDone = nd;
    end
  end

  always @(negedge clk) begin
    nChecks++;
    if (busy !== mBusy) begin
      nFail++;
      $display("FAIL %s cycle %0d busy: actual %b expected %b", phase, cyc, busy, mBusy);
    end
    nChecks++;
    if (done !== mDone) begin
      nFail++;
      $display("FAIL %s cycle %0d done: actual %b expected %b", phase, cyc, done, mDone);
    end
    cyc++;
    if (cyc > 100000) begin
      nFail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks + 1 - nFail, nChecks + 1);
      $finish;
    end
  end

  task automatic issue(input int op, input int lo, input int hi, input logic [15:0] junk);
    logic [63:0] w;
    w = (64'(hi) << 20) | 64'(lo);
    tbOp = op; tbLo = lo; tbHi = hi;
    instLo = w[31:0];
    instHi = {8'(op), junk, w[39:32]};
    instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    tbOp = 0;
  endtask

  task automatic walk(input int start, input int step, input int n);
    for (int i = 0; i < n; i++) begin
      scanLine = 20'(start + i * step);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    phase = "R2";  // inside wait, approach from below
    scanLine = 100; issue(5, 200, 300, 16'h0);
    walk(190, 1, 20);

    phase = "R5";  // inclusive upper bound from above, one-line window
    scanLine = 80; issue(5, 50, 60, 16'h0);
    walk(70, -1, 15);
    scanLine = 70; issue(5, 77, 77, 16'h0);
    walk(72, 1, 10);

    phase = "R3";  // outside wait
    scanLine = 15; issue(6, 10, 20, 16'h0);
    walk(15, 0, 5); walk(18, 1, 6);
    scanLine = 15; issue(6, 10, 20, 16'h0);
    walk(12, -1, 5);

    phase = "R10";
    scanLine = 0; issue(6, 0, 0, 16'h0);
    walk(0, 0, 6); walk(1, 0, 3);

    phase = "R7";
    scanLine = 500; @(negedge clk);
    issue(5, 400, 600, 16'h0);
    walk(500, 0, 3);

    phase = "R6";  // back-to-back, accept on done cycle
    scanLine = 30; issue(5, 30, 40, 16'h0);
    @(negedge clk);
    issue(6, 30, 40, 16'h0);
    walk(35, 3, 6);

    phase = "R8";
    scanLine = 10; issue(5, 900, 950, 16'h0);
    walk(10, 0, 2);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    walk(920, 0, 3);
    scanLine = 10; issue(5, 900, 950, 16'h0);
    scanLine = 910; @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    walk(910, 0, 3);
    abort = 1'b1; walk(910, 0, 2); abort = 1'b0;

    phase = "R9";
    scanLine = 5; issue(3, 0, 100, 16'h0);
    walk(5, 0, 3);
    issue(5, 300, 400, 16'h0);
    issue(5, 0, 100, 16'h0);
    walk(5, 0, 3); walk(350, 0, 3);

    phase = "R4";
    scanLine = 20'h2346; issue(5, 20'h1000, 20'h2345, 16'hA5C3);
    walk(20'h2346, 0, 3); walk(20'h2345, 0, 3);
    scanLine = 20'h0FFF; issue(6, 20'h01234, 20'hABCDE, 16'hFFFF);
    walk(20'hABCDE, 0, 3); walk(20'hABCDF, 0, 3);

    walk(0, 0, 3);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule